// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block holds the program counter of a 32-bit processor with fixed-size, word-aligned instructions. Each cycle it decides the following fetch address from the current instruction word and the two register operands that the rest of the datapath has read for it. Three cases are possible. The unit can step to the next word. It can take a conditional branch whose target is relative to the next word. It can take a jump whose target is formed from the upper PC bits and a field of the instruction.

The next address and a taken flag are produced combinationally in the same cycle. The PC register loads the next address on a clock edge when enable is high. A synchronous reset returns the PC to address zero. Instruction memory, the register file and the ALU are outside this block.

Top module: `pc_next_unit`

## Requirements
- R1: When `rst` is high at a clock edge, `pc_o` becomes 0x0000_0000 after that edge, whatever the other inputs are.
- R2: For an opcode (instruction bits 31..26) other than 2, 4 or 5, `npc_o` equals `pc_o` + 4 and `taken_o` is 0.
- R3: For opcode 4, when `rs_val_i` equals `rt_val_i`, `npc_o` = (`pc_o` + 4) + (sign-extended bits 15..0 × 4) and `taken_o` is 1. When the operands differ, `npc_o` = `pc_o` + 4 and `taken_o` is 0.
- R4: For opcode 5 the condition is inverted. The branch target and `taken_o` = 1 apply when the operands differ. `pc_o` + 4 and `taken_o` = 0 apply when they are equal.
- R5: For opcode 2, `npc_o` = {`pc_o`[31:28], instruction bits 25..0, 2'b00} and `taken_o` is 1, regardless of the operand values.
- R6: When `en` is low and `rst` is low, `pc_o` keeps its value across the clock edge.
- R7: When `en` is high and `rst` is low, `pc_o` takes the value `npc_o` had before the clock edge.
- R8: Address arithmetic wraps modulo 2^32. A backward branch below zero lands near the top of the address space, and stepping past 0xFFFF_FFFC returns to 0.
- R9: An opcode of 0 never redirects the PC, even when the operands are equal.
- R10: `pc_o` bits 1..0 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low holds the PC |
| instr_i | input | 32 | Instruction word at the current PC |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| pc_o | output | 32 | Current program counter |
| npc_o | output | 32 | Next program counter |
| taken_o | output | 1 | High for a taken branch or a jump |

## Verification
The only state in the block is the PC register. A wrong value there shows up on `pc_o` in the cycle after the faulty edge. Because every target is computed from the PC, it then shows on `npc_o` in that same cycle. An error in the decode or target paths appears on `npc_o` and `taken_o` combinationally, in the cycle the instruction is presented. It also appears on `pc_o` one edge later when enable is high. The bench therefore compares all three outputs every cycle against a model advanced from the requirements. A mistake is caught at most one cycle after it happens.

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter int XLEN = 32,
  parameter int OPW = 6,
  parameter int IMMW = 16,
  parameter int TGTW = 26,
  parameter logic [OPW-1:0] OP_JMP = 6'd2,
  parameter logic [OPW-1:0] OP_BEQ = 6'd4,
  parameter logic [OPW-1:0] OP_BNE = 6'd5,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o,
  output logic            taken_o
);
  localparam int HIW = XLEN - TGTW - 2;
  localparam int EXTW = XLEN - IMMW - 2;

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc;
  logic [OPW-1:0]  opc;
  logic [IMMW-1:0] imm;
  logic            same, is_jmp, is_beq, is_bne, br_take;

  assign opc    = instr_i[XLEN-1 -: OPW];
  assign imm    = instr_i[IMMW-1:0];
  assign same   = (rs_val_i == rt_val_i);
  assign is_jmp = (opc == OP_JMP);
  assign is_beq = (opc == OP_BEQ);
  assign is_bne = (opc == OP_BNE);

  assign seq_pc = pc_q + XLEN'(4);
  assign br_pc  = seq_pc + {{EXTW{imm[IMMW-1]}}, imm, 2'b00};
  assign jmp_pc = {pc_q[XLEN-1 -: HIW], instr_i[TGTW-1:0], 2'b00};

  assign br_take = (is_beq & same) | (is_bne & ~same);
  assign taken_o = br_take | is_jmp;
  assign npc_o   = is_jmp ? jmp_pc : (br_take ? br_pc : seq_pc);

  always_ff @(posedge clk) begin
    if (rst)     pc_q <= RESET_PC;
    else if (en) pc_q <= npc_o;
  end

  assign pc_o = pc_q;

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> pc_o == RESET_PC);

  // R6
  hold_pc_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> pc_o == $past(pc_o));

  // R7
  advance_pc_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> pc_o == $past(npc_o));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    !taken_o |-> npc_o == pc_o + XLEN'(4));

  // R5
  jump_region_chk: assert property (@(posedge clk) disable iff (rst)
    is_jmp |-> taken_o && npc_o[XLEN-1 -: HIW] == pc_o[XLEN-1 -: HIW]);

  // R10
  align_chk: assert property (@(posedge clk) disable iff (rst)
    pc_o[1:0] == 2'b00 && npc_o[1:0] == 2'b00);
endmodule

// File: tb/test_pc_next_unit.sv
module test_pc_next_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rs_v = '0;
  logic [31:0] rt_v = '0;
  logic [31:0] pc_o, npc_o;
  logic        taken_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] npc;
    logic        tk;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [31:0] model_pc = '0;

  always #4 clk = ~clk;

  pc_next_unit i_pc_next_unit (
    .clk(clk), .rst(rst), .en(en), .instr_i(instr),
    .rs_val_i(rs_v), .rt_val_i(rt_v),
    .pc_o(pc_o), .npc_o(npc_o), .taken_o(taken_o)
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [25:0] body);
    return {op, body};
  endfunction

  task automatic step(input logic r, input logic e, input logic [31:0] ins,
                      input logic [31:0] a, input logic [31:0] b, input string tag);
    exp_t it;
    logic [5:0]  op;
    logic [31:0] seq, off;
    logic        tk;
    @(posedge clk);
    #1;
    rst = r; en = e; instr = ins; rs_v = a; rt_v = b;
    op  = ins[31:26];
    seq = model_pc + 32'd4;
    off = {{14{ins[15]}}, ins[15:0], 2'b00};
    it.pc = model_pc;
    it.tag = tag;
    tk = 1'b0;
    it.npc = seq;
    if (op == 6'd2) begin
      tk = 1'b1;
      it.npc = {model_pc[31:28], ins[25:0], 2'b00};
    end else if ((op == 6'd4 && a == b) || (op == 6'd5 && a != b)) begin
      tk = 1'b1;
      it.npc = seq + off;
    end
    it.tk = tk;
    sb.push_back(it);
    if (r) model_pc = 32'd0;
    else if (e) model_pc = it.npc;
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (pc_o !== it.pc) begin
        errors++;
        $display("FAIL %s pc: got %h expected %h", it.tag, pc_o, it.pc);
      end
      checks++;
      if (npc_o !== it.npc) begin
        errors++;
        $display("FAIL %s npc: got %h expected %h", it.tag, npc_o, it.npc);
      end
      checks++;
      if (taken_o !== it.tk) begin
        errors++;
        $display("FAIL %s taken: got %b expected %b", it.tag, taken_o, it.tk);
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    model_pc = 32'd0;
    step(0, 1, 32'h0000_0000, 32'd1, 32'd2, "R1/R2");
    step(0, 1, 32'h012A_4020, 32'd7, 32'd7, "R9");
    step(0, 1, mk(6'd8, 26'h2D5_FFCE), 32'd3, 32'd3, "R2");
    step(0, 1, mk(6'd4, 26'h0000003), 32'h55, 32'h55, "R3/R7");
    step(0, 1, mk(6'd4, 26'h0000003), 32'h55, 32'h56, "R3");
    step(0, 1, mk(6'd5, 26'h000FFFF), 32'h1, 32'h2, "R4");
    step(0, 1, mk(6'd5, 26'h000FFFF), 32'h9, 32'h9, "R4");
    step(0, 1, mk(6'd4, 26'h0007FFF), 32'h0, 32'h0, "R3");
    step(0, 0, mk(6'd2, 26'h0000040), 32'h0, 32'h1, "R6");
    step(0, 0, 32'h0000_0000, 32'h0, 32'h0, "R6");
    step(0, 1, mk(6'd2, 26'h0000040), 32'h0, 32'h1, "R5/R7");
    step(0, 1, mk(6'd4, 26'h0008000), 32'h4, 32'h4, "R3");
    step(1, 1, mk(6'd2, 26'h3FFFFFF), 32'h0, 32'h0, "R1");
    step(0, 1, mk(6'd4, 26'h000FFFE), 32'hA, 32'hA, "R8");
    step(0, 1, mk(6'd2, 26'h0000005), 32'h0, 32'h0, "R5/R8");
    step(0, 1, mk(6'd5, 26'h0000010), 32'h3, 32'h3, "R4");
    step(1, 0, 32'h0000_0000, 32'h0, 32'h0, "R1");
    step(0, 1, mk(6'd5, 26'h000FFFF), 32'h1, 32'h0, "R8");
    step(0, 1, 32'h0000_0000, 32'h0, 32'h0, "R8/R10");
    step(0, 1, 32'h0000_0000, 32'h0, 32'h0, "R8");
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule